// File: doc/BRIEF.md
# Instruction Fetch Translator with Hardware Micro-TLB Refill

This block turns instruction-fetch virtual addresses into physical addresses using two translation caches. A small fully associative micro-TLB answers most fetches in one cycle. It is backed by a larger fully associative main TLB. When the micro-TLB has no matching entry, a one-cycle hardware search of the main TLB runs. On a hit, the found entry is copied into the micro-TLB round-robin slot and the lookup is replayed. On a miss, a fetch-miss exception pulse is raised and the micro-TLB is left alone.

Software fills only the main TLB. It presents a high word (virtual page and address-space tag), a low word (physical page and attributes) and a slot index, then pulses a load strobe. Entries can be 1 KB, 4 KB, 64 KB or 1 MB pages. An entry can be private to one address-space tag, or shared by all tags.

The fetcher holds `fetch_req` and `fetch_va` steady until it sees either `fetch_done` or `fetch_miss_exc` for one cycle, then drops the request.

Top module: `xlt_fetch_mmu`

## Requirements
- R1: After reset, `fetch_stall`, `fetch_done`, `fetch_miss_exc` and `fetch_multihit` are low and every entry in both caches is invalid, so the first fetch raises the exception.
- R2: A `tlb_load` pulse writes the main-TLB slot given by `repl_slot`. The high word has the virtual page in bits 31:10 and the tag in bits 7:0. The low word has the physical page in bits 28:10, valid in bit 8, size code {bit 7, bit 4}, protection in bits 6:5, cacheable in bit 3, dirty in bit 2, shared in bit 1 and write-through in bit 0. A later load to the same slot replaces the earlier entry.
- R3: A fetch that hits the micro-TLB gives `fetch_done` on the first clock edge after the request is seen, with no stall.
- R4: A micro-TLB miss that hits the main TLB raises `fetch_stall` for exactly one cycle (the search) and gives `fetch_done` on the third edge. A repeat fetch to the same page then completes in one cycle.
- R5: A miss in both caches gives a one-cycle `fetch_miss_exc` on the second edge, with no `fetch_done`. `fetch_done` and `fetch_miss_exc` are never high together.
- R6: The page is compared above the offset that the size code selects: 00 = 1 KB, 01 = 4 KB, 10 = 64 KB, 11 = 1 MB. `fetch_pa` is the physical page above that offset, joined to the untranslated offset bits.
- R7: An entry matches only if its tag equals `cur_asid`, or if its shared bit is set.
- R8: An entry whose valid bit is 0 never matches.
- R9: If several main-TLB entries match, the lowest index is used and `fetch_multihit` is high together with that fetch's `fetch_done`. Otherwise it stays low.
- R10: The micro-TLB holds 4 entries, filled round-robin from slot 0. A fifth distinct refill evicts the first page and keeps the second.
- R11: A `tlb_load` invalidates every micro-TLB entry, so a page cached before the load is fetched again through the main TLB and picks up the new content.
- R12: `fetch_prot`, `fetch_cacheable`, `fetch_dirty` and `fetch_wthru` carry the matching entry's attributes while `fetch_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_asid | input | 8 | Current address-space tag |
| fetch_req | input | 1 | Fetch translation request, held until done or exception |
| fetch_va | input | 32 | Fetch virtual address |
| fetch_stall | output | 1 | Main-TLB search in progress |
| fetch_done | output | 1 | One-cycle translation-complete pulse |
| fetch_pa | output | 29 | Physical address, valid with `fetch_done` |
| fetch_prot | output | 2 | Protection code of the hit entry |
| fetch_cacheable | output | 1 | Cacheable attribute of the hit entry |
| fetch_dirty | output | 1 | Dirty attribute of the hit entry |
| fetch_wthru | output | 1 | Write-through attribute of the hit entry |
| fetch_miss_exc | output | 1 | One-cycle fetch-miss exception pulse |
| fetch_multihit | output | 1 | Several main-TLB entries matched this fetch |
| tlb_load | input | 1 | Load strobe for one main-TLB entry |
| pte_hi | input | 32 | Load data: virtual page and tag |
| pte_lo | input | 32 | Load data: physical page and attributes |
| repl_slot | input | 6 | Main-TLB slot written by the load |

## Verification
The bench times each fetch in clock edges, so a design that skipped the replay, or stalled for more than the single search cycle, shows the wrong latency rather than only a wrong address.

Page sizes are probed at the last byte inside a page and the first byte past it. A mask that is off by one size would either translate the second address or corrupt the high offset bits.

The fifth-refill eviction and the load-time invalidation are both checked through latency. A wrong round-robin pointer would evict the second page instead of the first, and a missing invalidation would return the stale physical address.

Two overlapping entries of different sizes check that the lower index wins and that the multi-match flag rises only on that fetch and not on the later one served from the micro-TLB.

// File: rtl/xlt_pkg.sv
package xlt_pkg;

   localparam int VA_W   = 32;
   localparam int PA_W   = 29;
   localparam int ASID_W = 8;
   localparam int PG_LSB = 10;
   localparam int VPN_W  = VA_W - PG_LSB;
   localparam int PPN_W  = PA_W - PG_LSB;

   typedef struct packed {
      logic              vld;
      logic [VPN_W-1:0]  vpn;
      logic [ASID_W-1:0] asid;
      logic [PPN_W-1:0]  ppn;
      logic [1:0]        sz;
      logic [1:0]        prot;
      logic              dirty;
      logic              cache;
      logic              shared;
      logic              wthru;
   } xlt_entry_t;

   // offset mask selected by the size code
   function automatic logic [VA_W-1:0] off_mask(input logic [1:0] sz);
      logic [VA_W-1:0] m;
      case (sz)
         2'b00:   m = VA_W'(32'h0000_03FF);
         2'b01:   m = VA_W'(32'h0000_0FFF);
         2'b10:   m = VA_W'(32'h0000_FFFF);
         default: m = VA_W'(32'h000F_FFFF);
      endcase
      return m;
   endfunction

   function automatic logic ent_hit(input xlt_entry_t e,
                                    input logic [VA_W-1:0] va,
                                    input logic [ASID_W-1:0] asid);
      logic [VA_W-1:0] ev;
      logic [VA_W-1:0] m;
      ev = {e.vpn, {PG_LSB{1'b0}}};
      m  = off_mask(e.sz);
      return e.vld && (((ev ^ va) & ~m) == '0) && (e.shared || (e.asid == asid));
   endfunction

   function automatic logic [PA_W-1:0] xlate_pa(input xlt_entry_t e,
                                                input logic [VA_W-1:0] va);
      logic [VA_W-1:0] m;
      logic [PA_W-1:0] pm;
      m  = off_mask(e.sz);
      pm = m[PA_W-1:0];
      return ({e.ppn, {PG_LSB{1'b0}}} & ~pm) | (va[PA_W-1:0] & pm);
   endfunction

   function automatic xlt_entry_t unpack_cmd(input logic [31:0] hi,
                                             input logic [31:0] lo);
      xlt_entry_t e;
      e.vpn    = hi[31:PG_LSB];
      e.asid   = hi[ASID_W-1:0];
      e.ppn    = lo[PA_W-1:PG_LSB];
      e.vld    = lo[8];
      e.sz     = {lo[7], lo[4]};
      e.prot   = lo[6:5];
      e.cache  = lo[3];
      e.dirty  = lo[2];
      e.shared = lo[1];
      e.wthru  = lo[0];
      return e;
   endfunction

endpackage

// File: rtl/xlt_cam.sv
module xlt_cam
   import xlt_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  xlt_entry_t [DEPTH-1:0] ents,
   input  logic [VA_W-1:0]        va,
   input  logic [ASID_W-1:0]      asid,
   output logic                   hit,
   output logic [IDX_W-1:0]       idx,
   output logic                   multi
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("xlt_cam: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0] match;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = ent_hit(ents[g], va, asid);
   end

   // lowest index wins
   always_comb begin
      idx = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (match[k]) idx = IDX_W'(k);
      end
   end

   assign hit   = |match;
   assign multi = (match & (match - DEPTH'(1))) != '0;

endmodule

// File: rtl/xlt_main_store.sv
module xlt_main_store
   import xlt_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_idx,
   input  xlt_entry_t             wr_ent,
   output xlt_entry_t [DEPTH-1:0] ents
);

   if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("xlt_main_store: DEPTH must be a power of two");
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ents[g] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            ents[g] <= wr_ent;
      end
   end

endmodule

// File: rtl/xlt_micro_store.sv
module xlt_micro_store
   import xlt_pkg::*;
#(
   parameter int DEPTH = 4,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic                   fill_en,
   input  xlt_entry_t             fill_ent,
   output xlt_entry_t [DEPTH-1:0] ents
);

   if (DEPTH < 2 || (1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("xlt_micro_store: DEPTH must be a power of two, at least 2");
   end

   logic [IDX_W-1:0] rr_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rr_ptr <= '0;
      else if (flush)
         rr_ptr <= '0;
      else if (fill_en)
         rr_ptr <= rr_ptr + IDX_W'(1);
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ents[g] <= '0;
         else if (flush)
            ents[g].vld <= 1'b0;
         else if (fill_en && (rr_ptr == IDX_W'(g)))
            ents[g] <= fill_ent;
      end
   end

endmodule

// File: rtl/xlt_fetch_mmu.sv
module xlt_fetch_mmu
   import xlt_pkg::*;
#(
   parameter int MICRO_DEPTH = 4,
   parameter int MAIN_DEPTH  = 64,
   localparam int MI_W = $clog2(MICRO_DEPTH),
   localparam int MA_W = $clog2(MAIN_DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        cur_asid,
   input  logic              fetch_req,
   input  logic [31:0]       fetch_va,
   output logic              fetch_stall,
   output logic              fetch_done,
   output logic [28:0]       fetch_pa,
   output logic [1:0]        fetch_prot,
   output logic              fetch_cacheable,
   output logic              fetch_dirty,
   output logic              fetch_wthru,
   output logic              fetch_miss_exc,
   output logic              fetch_multihit,
   input  logic              tlb_load,
   input  logic [31:0]       pte_hi,
   input  logic [31:0]       pte_lo,
   input  logic [MA_W-1:0]   repl_slot
);

   typedef enum logic {ST_IDLE, ST_SEARCH} st_t;

   st_t                          st;
   xlt_entry_t [MICRO_DEPTH-1:0] mi_ents;
   xlt_entry_t [MAIN_DEPTH-1:0]  ma_ents;
   logic                         mi_hit, mi_multi, ma_hit, ma_multi;
   logic [MI_W-1:0]              mi_idx;
   logic [MA_W-1:0]              ma_idx;
   logic                         mh_pend;
   logic                         fill_en;
   xlt_entry_t                   mi_sel;

   xlt_main_store #(.DEPTH(MAIN_DEPTH)) u_main (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (tlb_load),
      .wr_idx (repl_slot),
      .wr_ent (unpack_cmd(pte_hi, pte_lo)),
      .ents   (ma_ents)
   );

   xlt_micro_store #(.DEPTH(MICRO_DEPTH)) u_micro (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (tlb_load),
      .fill_en  (fill_en),
      .fill_ent (ma_ents[ma_idx]),
      .ents     (mi_ents)
   );

   xlt_cam #(.DEPTH(MICRO_DEPTH)) u_mi_cam (
      .ents  (mi_ents),
      .va    (fetch_va),
      .asid  (cur_asid),
      .hit   (mi_hit),
      .idx   (mi_idx),
      .multi (mi_multi)
   );

   xlt_cam #(.DEPTH(MAIN_DEPTH)) u_ma_cam (
      .ents  (ma_ents),
      .va    (fetch_va),
      .asid  (cur_asid),
      .hit   (ma_hit),
      .idx   (ma_idx),
      .multi (ma_multi)
   );

   assign mi_sel      = mi_ents[mi_idx];
   assign fill_en     = (st == ST_SEARCH) && ma_hit;
   assign fetch_stall = (st == ST_SEARCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st              <= ST_IDLE;
         fetch_done      <= 1'b0;
         fetch_miss_exc  <= 1'b0;
         fetch_multihit  <= 1'b0;
         mh_pend         <= 1'b0;
         fetch_pa        <= '0;
         fetch_prot      <= '0;
         fetch_cacheable <= 1'b0;
         fetch_dirty     <= 1'b0;
         fetch_wthru     <= 1'b0;
      end else begin
         fetch_done     <= 1'b0;
         fetch_miss_exc <= 1'b0;
         fetch_multihit <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (fetch_req) begin
                  if (mi_hit) begin
                     fetch_done      <= 1'b1;
                     fetch_pa        <= xlate_pa(mi_sel, fetch_va);
                     fetch_prot      <= mi_sel.prot;
                     fetch_cacheable <= mi_sel.cache;
                     fetch_dirty     <= mi_sel.dirty;
                     fetch_wthru     <= mi_sel.wthru;
                     fetch_multihit  <= mh_pend && !mi_multi;
                     mh_pend         <= 1'b0;
                  end else begin
                     st      <= ST_SEARCH;
                     mh_pend <= 1'b0;
                  end
               end
            end
            default: begin
               st <= ST_IDLE;
               if (ma_hit)
                  mh_pend <= ma_multi;
               else
                  fetch_miss_exc <= 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/xlt_fetch_mmu_chk.sv
module xlt_fetch_mmu_chk (
   input logic clk,
   input logic rst_n,
   input logic fetch_req,
   input logic fetch_stall,
   input logic fetch_done,
   input logic fetch_miss_exc,
   input logic fetch_multihit
);

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> !fetch_done && !fetch_stall && !fetch_miss_exc && !fetch_multihit); // R1

   AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_done |-> $past(fetch_req)); // R3

   AST_DONE_UNSTALLED: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_done |-> !fetch_stall); // R3

   AST_SEARCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_stall |=> !fetch_stall); // R4

   AST_EXC_AFTER_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_miss_exc |-> $past(fetch_stall)); // R5

   AST_DONE_EXC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(fetch_done && fetch_miss_exc)); // R5

   AST_MULTI_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_multihit |-> fetch_done); // R9

endmodule

bind xlt_fetch_mmu xlt_fetch_mmu_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .fetch_req      (fetch_req),
   .fetch_stall    (fetch_stall),
   .fetch_done     (fetch_done),
   .fetch_miss_exc (fetch_miss_exc),
   .fetch_multihit (fetch_multihit)
);

// File: tb/tb_xlt_fetch_mmu.sv
`timescale 1ns/1ps
module tb_xlt_fetch_mmu;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  cur_asid = 8'h11;
   logic        fetch_req = 1'b0;
   logic [31:0] fetch_va = '0;
   logic        fetch_stall, fetch_done, fetch_cacheable, fetch_dirty, fetch_wthru;
   logic        fetch_miss_exc, fetch_multihit;
   logic [28:0] fetch_pa;
   logic [1:0]  fetch_prot;
   logic        tlb_load = 1'b0;
   logic [31:0] pte_hi = '0, pte_lo = '0;
   logic [5:0]  repl_slot = '0;

   int n_chk = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   xlt_fetch_mmu dut (
      .clk(clk), .rst_n(rst_n), .cur_asid(cur_asid),
      .fetch_req(fetch_req), .fetch_va(fetch_va),
      .fetch_stall(fetch_stall), .fetch_done(fetch_done), .fetch_pa(fetch_pa),
      .fetch_prot(fetch_prot), .fetch_cacheable(fetch_cacheable),
      .fetch_dirty(fetch_dirty), .fetch_wthru(fetch_wthru),
      .fetch_miss_exc(fetch_miss_exc), .fetch_multihit(fetch_multihit),
      .tlb_load(tlb_load), .pte_hi(pte_hi), .pte_lo(pte_lo), .repl_slot(repl_slot)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_hi(input logic [31:0] va, input logic [7:0] asid);
      return {va[31:10], 2'b00, asid};
   endfunction

   function automatic logic [31:0] mk_lo(input logic [28:0] pa, input bit v,
                                         input logic [1:0] sz, input logic [1:0] prot,
                                         input bit c, input bit d, input bit sh, input bit wt);
      return {3'b000, pa[28:10], 1'b0, v, sz[1], prot, sz[0], c, d, sh, wt};
   endfunction

   task automatic load(input logic [5:0] slot, input logic [31:0] hi, input logic [31:0] lo);
      tlb_load  = 1'b1;
      repl_slot = slot;
      pte_hi    = hi;
      pte_lo    = lo;
      @(negedge clk);
      tlb_load  = 1'b0;
   endtask

   // latency in edges: 1 micro hit, 3 refill, 2 exception
   task automatic fetch(input logic [31:0] va, input int exp_lat, input bit exp_exc,
                        input logic [28:0] exp_pa, input bit exp_mh, input string tag);
      int lat;
      bit got, stall_seen;
      lat = 0; got = 0; stall_seen = 0;
      fetch_req = 1'b1;
      fetch_va  = va;
      while (!got && lat < 10) begin
         @(negedge clk);
         lat++;
         if (fetch_stall) stall_seen = 1;
         if (fetch_done || fetch_miss_exc) got = 1;
      end
      chk(lat == exp_lat, tag, "latency", lat, exp_lat);
      chk(fetch_miss_exc == exp_exc, tag, "exception", fetch_miss_exc, exp_exc);
      chk(fetch_done == !exp_exc, tag, "done", fetch_done, !exp_exc);
      chk(stall_seen == (exp_lat > 1), tag, "stall seen", stall_seen, exp_lat > 1);
      if (!exp_exc) begin
         chk(fetch_pa == exp_pa, tag, "pa", fetch_pa, exp_pa);
         chk(fetch_multihit == exp_mh, tag, "multihit", fetch_multihit, exp_mh);
      end
      fetch_req = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk(!fetch_stall && !fetch_done && !fetch_miss_exc && !fetch_multihit,
          "R1", "outputs after reset",
          {fetch_stall, fetch_done, fetch_miss_exc, fetch_multihit}, 0);
      fetch(32'h0000_1000, 2, 1, '0, 0, "R1");
   endtask

   task automatic t_refill;
      // slot 5, 4 KB, prot 2, cacheable, dirty
      load(6'd5, mk_hi(32'h0040_0000, 8'h11), mk_lo(29'h0123_4000, 1, 2'b01, 2'b10, 1, 1, 0, 0));
      fetch(32'h0040_0ABC, 3, 0, 29'h0123_4ABC, 0, "R4");
      chk(fetch_prot == 2'b10 && fetch_cacheable && fetch_dirty && !fetch_wthru, "R12",
          "attributes", {fetch_prot, fetch_cacheable, fetch_dirty, fetch_wthru}, 5'b10110);
      fetch(32'h0040_0123, 1, 0, 29'h0123_4123, 0, "R3");
   endtask

   task automatic t_sizes;
      load(6'd10, mk_hi(32'h1000_0400, 8'h11), mk_lo(29'h0000_0800, 1, 2'b00, 0, 0, 0, 0, 1));
      load(6'd11, mk_hi(32'h2003_0000, 8'h11), mk_lo(29'h0045_0000, 1, 2'b10, 0, 0, 0, 0, 0));
      load(6'd12, mk_hi(32'h3010_0000, 8'h11), mk_lo(29'h1F80_0000, 1, 2'b11, 0, 0, 0, 0, 0));
      fetch(32'h1000_07FF, 3, 0, 29'h0000_0BFF, 0, "R6");
      chk(fetch_wthru == 1'b1, "R12", "write-through", fetch_wthru, 1);
      fetch(32'h1000_0800, 2, 1, '0, 0, "R6");
      fetch(32'h2003_ABCD, 3, 0, 29'h0045_ABCD, 0, "R6");
      fetch(32'h2004_0000, 2, 1, '0, 0, "R6");
      fetch(32'h301F_FFFC, 3, 0, 29'h1F8F_FFFC, 0, "R6");
   endtask

   task automatic t_asid;
      load(6'd20, mk_hi(32'h5000_0000, 8'h22), mk_lo(29'h0000_5000, 1, 2'b01, 0, 0, 0, 0, 0));
      load(6'd21, mk_hi(32'h6000_0000, 8'h33), mk_lo(29'h0000_6000, 1, 2'b01, 0, 0, 0, 1, 0));
      fetch(32'h5000_0010, 2, 1, '0, 0, "R7");
      fetch(32'h6000_0020, 3, 0, 29'h0000_6020, 0, "R7");
      cur_asid = 8'h22;
      fetch(32'h5000_0010, 3, 0, 29'h0000_5010, 0, "R7");
      cur_asid = 8'h11;
   endtask

   task automatic t_invalid;
      load(6'd30, mk_hi(32'h7000_0000, 8'h11), mk_lo(29'h0000_7000, 0, 2'b01, 0, 0, 0, 1, 0));
      fetch(32'h7000_0004, 2, 1, '0, 0, "R8");
   endtask

   task automatic t_multi;
      load(6'd40, mk_hi(32'h8000_0000, 8'h11), mk_lo(29'h0000_A000, 1, 2'b01, 0, 0, 0, 0, 0));
      load(6'd41, mk_hi(32'h8000_0000, 8'h11), mk_lo(29'h0000_0000, 1, 2'b10, 0, 0, 0, 0, 0));
      fetch(32'h8000_0010, 3, 0, 29'h0000_A010, 1, "R9");
      fetch(32'h8000_0020, 1, 0, 29'h0000_A020, 0, "R9");
   endtask

   task automatic t_slot_overwrite;
      load(6'd60, mk_hi(32'hA000_0000, 8'h11), mk_lo(29'h000A_0000, 1, 2'b01, 0, 0, 0, 0, 0));
      load(6'd60, mk_hi(32'hB000_0000, 8'h11), mk_lo(29'h000B_0000, 1, 2'b01, 0, 0, 0, 0, 0));
      fetch(32'hA000_0000, 2, 1, '0, 0, "R2");
      fetch(32'hB000_0044, 3, 0, 29'h000B_0044, 0, "R2");
   endtask

   task automatic t_flush;
      fetch(32'h0040_0000, 3, 0, 29'h0123_4000, 0, "R11");
      fetch(32'h0040_0000, 1, 0, 29'h0123_4000, 0, "R11");
      load(6'd5, mk_hi(32'h0040_0000, 8'h11), mk_lo(29'h0155_5000, 1, 2'b01, 0, 0, 0, 0, 0));
      fetch(32'h0040_0004, 3, 0, 29'h0155_5004, 0, "R11");
   endtask

   task automatic t_round_robin;
      for (int k = 0; k < 5; k++)
         load(6'(50 + k), mk_hi(32'h9000_0000 + 32'(k) * 32'h1000, 8'h11),
              mk_lo(29'h0090_0000 + 29'(k) * 29'h1000, 1, 2'b01, 0, 0, 0, 0, 0));
      for (int k = 0; k < 5; k++)
         fetch(32'h9000_0000 + 32'(k) * 32'h1000, 3, 0, 29'h0090_0000 + 29'(k) * 29'h1000, 0, "R10");
      fetch(32'h9000_1008, 1, 0, 29'h0090_1008, 0, "R10");
      fetch(32'h9000_0008, 3, 0, 29'h0090_0008, 0, "R10");
   endtask

   task automatic finish_run;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL all watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_refill();
      t_sizes();
      t_asid();
      t_invalid();
      t_multi();
      t_slot_overwrite();
      t_flush();
      t_round_robin();
      finish_run();
   end

endmodule